// File: doc/BRIEF.md
# PCI Bridge System-Error Reporting

This block is the error-reporting slice of a bridge that joins a primary PCI bus to a secondary PCI bus. Each side of the bridge reports its error events to the block as one-cycle strobes. The block keeps a sticky status register for each side. It decides whether the bridge must raise a system error on the primary bus. When it must, it drives an active-low, open-drain style `serr_n` output for one clock.

Two secondary-side conditions are turned into a primary-side system error. The first is a system error received on the secondary bus. The second is a master abort on posted-write data that the bridge had already acknowledged to its initiator. An address parity error seen on the primary bus also raises a system error. The block records the cause of each system error in a separate reason register. Software reads and clears all registers through a plain register port, and only when the command register's system-error enable is set does the bridge signal anything upward.

All registers are 16 bits wide. The register port uses a 2-bit index: 0 is the command register, 1 is the primary status register, 2 is the secondary status register and 3 is the reason register. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `brg_err_report`

## Requirements
- R1: After reset, the command register and the reason register read 0, both status registers read only their fixed capability bits (0x0280 by default), and `serr_n` is high.
- R2: In the command register (index 0), bits 9:0 are writable and read back as written. Bits 15:10 always read 0. Bit 8 is the system-error enable and bit 6 is the parity-error response enable.
- R3: A `sec_serr` strobe sets bit 14 of the secondary status register (index 2), whether or not the system-error enable is set.
- R4: When command bit 8 is set, any cause raises a system error. The causes are `sec_serr`, `sec_posted_mabort` and `pri_addr_perr`. `serr_n` goes low for exactly the one clock after the cause cycle, and in that same edge bit 14 of the primary status register (index 1) is set.
- R5: When command bit 8 is clear, causes still set their secondary status bits. `serr_n` stays high, bit 14 of the primary status register stays clear, and the reason register is not loaded.
- R6: `sec_mabort` sets bit 13 of the secondary status register. `sec_posted_mabort` also sets that bit.
- R7: When command bit 8 is set, the reason register (index 3) takes a bit for each cause: bit 0 for `sec_serr`, bit 1 for `pri_addr_perr` and bit 4 for `sec_posted_mabort`. A posted-write master abort therefore reads 0x10. Causes that arrive in the same cycle set all of their bits together.
- R8: An address parity strobe on a side sets bit 15 of that side's status register.
- R9: A data parity strobe on a side always sets bit 15 of that side's status register. It sets bit 8 only while command bit 6 is set.
- R10: On each side, a signaled target abort sets bit 11 and a received target abort sets bit 12. On the primary side, a received master abort sets bit 13.
- R11: The error bits are write-one-to-clear. These are bits 15, 14, 13, 12, 11 and 8 of both status registers, and bits 4, 1 and 0 of the reason register. Writing 0 leaves a bit unchanged. If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R12: Status bits other than the error bits read as fixed constants, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the indexed register |
| pri_addr_perr | input | 1 | Address parity error seen on the primary bus |
| pri_data_perr | input | 1 | Data parity error seen on the primary bus |
| pri_tabort_sig | input | 1 | Bridge signaled target abort on the primary bus |
| pri_tabort_rcv | input | 1 | Bridge received target abort on the primary bus |
| pri_mabort_rcv | input | 1 | Bridge received master abort on the primary bus |
| sec_serr | input | 1 | System error received on the secondary bus |
| sec_addr_perr | input | 1 | Address parity error seen on the secondary bus |
| sec_data_perr | input | 1 | Data parity error seen on the secondary bus |
| sec_tabort_sig | input | 1 | Bridge signaled target abort on the secondary bus |
| sec_tabort_rcv | input | 1 | Bridge received target abort on the secondary bus |
| sec_mabort | input | 1 | Master abort while the bridge was master on the secondary bus |
| sec_posted_mabort | input | 1 | Master abort on already-acknowledged posted-write data |
| serr_n | output | 1 | Active-low system-error pulse on the primary bus |

## Verification
The bench builds the block with its default parameters: capability bits 0x0280 on both sides and an 8-bit reason field. With nonzero capability bits, a write of all ones to a status register shows whether the W1C path disturbs bits that must stay fixed. With an 8-bit reason field, all three cause bits can be seen at once, including the combined value 0x13 when all three causes arrive in one cycle. The bench runs each cause with the system-error enable both clear and set. It also drives an event and a clearing write in the same cycle to check that the set wins.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;
  localparam int DW    = 16;
  localparam int AW    = 2;
  localparam int CMD_W = 10;

  // status bit positions (shared by both sides)
  localparam int B_DPE  = 15;
  localparam int B_SERR = 14;
  localparam int B_RMA  = 13;
  localparam int B_RTA  = 12;
  localparam int B_STA  = 11;
  localparam int B_DPAR = 8;

  // command bit positions
  localparam int C_PERR = 6;
  localparam int C_SERR = 8;

  // reason bit positions
  localparam int R_SSERR = 0;
  localparam int R_PAPE  = 1;
  localparam int R_PWMA  = 4;

  localparam logic [AW-1:0] A_CMD   = 2'd0;
  localparam logic [AW-1:0] A_PSTAT = 2'd1;
  localparam logic [AW-1:0] A_SSTAT = 2'd2;
  localparam logic [AW-1:0] A_RSN   = 2'd3;

  localparam logic [DW-1:0] ERR_MASK = 16'hF900;

  typedef struct packed {
    logic addr_perr;
    logic data_perr;
    logic tabort_sig;
    logic tabort_rcv;
    logic mabort;
  } side_evt_t;

  function automatic logic [DW-1:0] side_bits(input side_evt_t e, input logic perr_resp);
    logic [DW-1:0] v;
    v         = '0;
    v[B_DPE]  = e.addr_perr | e.data_perr;
    v[B_DPAR] = e.data_perr & perr_resp;
    v[B_STA]  = e.tabort_sig;
    v[B_RTA]  = e.tabort_rcv;
    v[B_RMA]  = e.mabort;
    return v;
  endfunction
endpackage

// File: rtl/brg_w1c_reg.sv
module brg_w1c_reg #(
  parameter int           W     = 16,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] FIXED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_i) | set_i) & MASK;
  end

  assign q_o = q | (FIXED & ~MASK);

  assert_sticky_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(q) & ~$past(clr_i)) & ~q) == '0));
endmodule

// File: rtl/brg_serr_gen.sv
module brg_serr_gen
  import brg_err_pkg::*;
#(
  parameter int RSN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serr_en,
  input  logic             perr_resp,
  input  side_evt_t        pri_evt,
  input  side_evt_t        sec_evt,
  input  logic             sec_serr,
  input  logic             sec_posted_mabort,
  output logic [DW-1:0]    pri_set,
  output logic [DW-1:0]    sec_set,
  output logic [RSN_W-1:0] rsn_set,
  output logic             serr_n_o
);
  logic [RSN_W-1:0] cause;
  logic             fire;
  logic             serr_n_q;
  side_evt_t        sec_mod;

  always_comb begin
    cause          = '0;
    cause[R_SSERR] = sec_serr;
    cause[R_PAPE]  = pri_evt.addr_perr;
    cause[R_PWMA]  = sec_posted_mabort;
  end

  assign fire    = serr_en & (|cause);
  assign rsn_set = serr_en ? cause : '0;

  always_comb begin
    sec_mod        = sec_evt;
    sec_mod.mabort = sec_evt.mabort | sec_posted_mabort;
    pri_set         = side_bits(pri_evt, perr_resp);
    pri_set[B_SERR] = fire;
    sec_set         = side_bits(sec_mod, perr_resp);
    sec_set[B_SERR] = sec_serr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serr_n_q <= 1'b1;
    else        serr_n_q <= ~fire;
  end

  assign serr_n_o = serr_n_q;

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(serr_en) |-> serr_n_q);
endmodule

// File: rtl/brg_err_report.sv
module brg_err_report
  import brg_err_pkg::*;
#(
  parameter logic [15:0] CAP_PRI = 16'h0280,
  parameter logic [15:0] CAP_SEC = 16'h0280,
  parameter int          RSN_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        pri_addr_perr,
  input  logic        pri_data_perr,
  input  logic        pri_tabort_sig,
  input  logic        pri_tabort_rcv,
  input  logic        pri_mabort_rcv,
  input  logic        sec_serr,
  input  logic        sec_addr_perr,
  input  logic        sec_data_perr,
  input  logic        sec_tabort_sig,
  input  logic        sec_tabort_rcv,
  input  logic        sec_mabort,
  input  logic        sec_posted_mabort,
  output logic        serr_n
);
  localparam logic [RSN_W-1:0] RSN_MASK =
    RSN_W'((1 << R_SSERR) | (1 << R_PAPE) | (1 << R_PWMA));

  logic [CMD_W-1:0] cmd_q;
  side_evt_t        pri_evt, sec_evt;
  logic [DW-1:0]    st_set [2];
  logic [DW-1:0]    st_q   [2];
  logic [RSN_W-1:0] rsn_set, rsn_q, rsn_clr;

  assign pri_evt = '{addr_perr: pri_addr_perr, data_perr: pri_data_perr,
                     tabort_sig: pri_tabort_sig, tabort_rcv: pri_tabort_rcv,
                     mabort: pri_mabort_rcv};
  assign sec_evt = '{addr_perr: sec_addr_perr, data_perr: sec_data_perr,
                     tabort_sig: sec_tabort_sig, tabort_rcv: sec_tabort_rcv,
                     mabort: sec_mabort};

  always_ff @(posedge clk) begin
    if (!rst_n)                            cmd_q <= '0;
    else if (reg_we && reg_addr == A_CMD)  cmd_q <= reg_wdata[CMD_W-1:0];
  end

  brg_serr_gen #(.RSN_W(RSN_W)) u_gen (
    .clk               (clk),
    .rst_n             (rst_n),
    .serr_en           (cmd_q[C_SERR]),
    .perr_resp         (cmd_q[C_PERR]),
    .pri_evt           (pri_evt),
    .sec_evt           (sec_evt),
    .sec_serr          (sec_serr),
    .sec_posted_mabort (sec_posted_mabort),
    .pri_set           (st_set[0]),
    .sec_set           (st_set[1]),
    .rsn_set           (rsn_set),
    .serr_n_o          (serr_n)
  );

  for (genvar s = 0; s < 2; s++) begin : g_stat
    localparam logic [AW-1:0] MY_ADDR = (s == 0) ? A_PSTAT : A_SSTAT;
    logic [DW-1:0] clr;
    assign clr = (reg_we && reg_addr == MY_ADDR) ? reg_wdata : '0;
    brg_w1c_reg #(
      .W     (DW),
      .MASK  (ERR_MASK),
      .FIXED ((s == 0) ? CAP_PRI : CAP_SEC)
    ) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[s]),
      .clr_i (clr),
      .q_o   (st_q[s])
    );
  end

  assign rsn_clr = (reg_we && reg_addr == A_RSN) ? reg_wdata[RSN_W-1:0] : '0;

  brg_w1c_reg #(.W(RSN_W), .MASK(RSN_MASK), .FIXED('0)) u_rsn (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rsn_set),
    .clr_i (rsn_clr),
    .q_o   (rsn_q)
  );

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = DW'(cmd_q);
      A_PSTAT: reg_rdata = st_q[0];
      A_SSTAT: reg_rdata = st_q[1];
      default: reg_rdata = DW'(rsn_q);
    endcase
  end

  assert_serr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> st_q[0][B_SERR]);
  assert_posted_reason_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_posted_mabort && cmd_q[C_SERR]) |-> rsn_q[R_PWMA]);
  assert_sec_serr_logged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_serr) |-> st_q[1][B_SERR]);
endmodule

// File: tb/brg_err_report_tb.sv
module brg_err_report_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [11:0] ev = '0;
  logic        serr_n;
  logic        rd_req = 1'b0;
  int          total = 0;
  int          bad = 0;

  // ev bit map
  localparam int E_PAPE = 0, E_PDPE = 1, E_PSTA = 2, E_PRTA = 3, E_PRMA = 4;
  localparam int E_SSERR = 5, E_SAPE = 6, E_SDPE = 7, E_SSTA = 8, E_SRTA = 9;
  localparam int E_SMA = 10, E_SPWMA = 11;
  localparam logic [1:0] CMD = 0, PST = 1, SST = 2, RSN = 3;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  brg_err_report dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pri_addr_perr(ev[E_PAPE]), .pri_data_perr(ev[E_PDPE]),
    .pri_tabort_sig(ev[E_PSTA]), .pri_tabort_rcv(ev[E_PRTA]),
    .pri_mabort_rcv(ev[E_PRMA]), .sec_serr(ev[E_SSERR]),
    .sec_addr_perr(ev[E_SAPE]), .sec_data_perr(ev[E_SDPE]),
    .sec_tabort_sig(ev[E_SSTA]), .sec_tabort_rcv(ev[E_SRTA]),
    .sec_mabort(ev[E_SMA]), .sec_posted_mabort(ev[E_SPWMA]),
    .serr_n(serr_n)
  );

  // monitor: pops expected read values and compares
  always @(negedge clk) begin
    exp_t e;
    if (rd_req) begin
      e = sb.pop_front();
      total++;
      if (reg_rdata !== e.exp) begin
        bad++;
        $display("FAIL %s: actual=0x%04h expected=0x%04h", e.tag, reg_rdata, e.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    sb.push_back(x);
    reg_addr = a; rd_req = 1'b1;
    @(negedge clk); #1; rd_req = 1'b0;
  endtask

  task automatic serr_chk(input logic e, input string tag);
    total++;
    if (serr_n !== e) begin
      bad++;
      $display("FAIL %s: serr_n actual=%b expected=%b", tag, serr_n, e);
    end
  endtask

  task automatic fire(input logic [11:0] v);
    step(); ev = v;
    step(); ev = '0;
  endtask

  task automatic clr_all();
    wr(PST, 16'hFFFF); wr(SST, 16'hFFFF); wr(RSN, 16'h00FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 / R12 reset state
    serr_chk(1'b1, "R1 serr_n idle");
    rd_chk(CMD, 16'h0000, "R1 cmd reset");
    rd_chk(PST, 16'h0280, "R1 pri status reset");
    rd_chk(SST, 16'h0280, "R12 sec status fixed bits");
    rd_chk(RSN, 16'h0000, "R1 reason reset");
    // R2 command reserved bits
    wr(CMD, 16'hFFFF);
    rd_chk(CMD, 16'h03FF, "R2 cmd reserved read zero");
    wr(CMD, 16'h0000);
    // R5 enable clear: logged, no pulse
    fire(12'(1 << E_SSERR));
    serr_chk(1'b1, "R5 no pulse when disabled");
    step();
    serr_chk(1'b1, "R5 no pulse later");
    rd_chk(SST, 16'h4280, "R3 received serr logged");
    rd_chk(PST, 16'h0280, "R5 pri signaled bit stays clear");
    rd_chk(RSN, 16'h0000, "R5 reason not loaded");
    fire(12'(1 << E_SMA));
    rd_chk(SST, 16'h6280, "R6 sec master abort");
    // R11 W1C
    wr(SST, 16'h0000);
    rd_chk(SST, 16'h6280, "R11 write zero keeps bits");
    wr(SST, 16'h4000);
    rd_chk(SST, 16'h2280, "R11 clear one bit");
    wr(SST, 16'hFFFF);
    rd_chk(SST, 16'h0280, "R12 fixed bits survive write");
    // R4 pulse with enable
    wr(CMD, 16'h0100);
    fire(12'(1 << E_SSERR));
    serr_chk(1'b0, "R4 pulse low");
    step();
    serr_chk(1'b1, "R4 pulse one clock");
    rd_chk(PST, 16'h4280, "R4 pri signaled serr");
    rd_chk(RSN, 16'h0001, "R7 reason sec serr");
    clr_all();
    fire(12'(1 << E_SPWMA));
    serr_chk(1'b0, "R4 posted abort pulse");
    rd_chk(RSN, 16'h0010, "R7 posted write reason 0x10");
    rd_chk(SST, 16'h2280, "R6 posted abort sets bit13");
    rd_chk(PST, 16'h4280, "R4 pri signaled on posted abort");
    clr_all();
    fire(12'((1 << E_SSERR) | (1 << E_SPWMA) | (1 << E_PAPE)));
    rd_chk(RSN, 16'h0013, "R7 simultaneous causes");
    rd_chk(PST, 16'hC280, "R8 pri address parity");
    clr_all();
    fire(12'(1 << E_SAPE));
    serr_chk(1'b1, "R8 sec addr parity no pulse");
    rd_chk(SST, 16'h8280, "R8 sec address parity");
    clr_all();
    // R9 data parity
    fire(12'((1 << E_PDPE) | (1 << E_SDPE)));
    rd_chk(PST, 16'h8280, "R9 pri data parity no resp");
    rd_chk(SST, 16'h8280, "R9 sec data parity no resp");
    clr_all();
    wr(CMD, 16'h0140);
    fire(12'((1 << E_PDPE) | (1 << E_SDPE)));
    rd_chk(PST, 16'h8380, "R9 pri data parity resp");
    rd_chk(SST, 16'h8380, "R9 sec data parity resp");
    clr_all();
    // R10 aborts
    fire(12'((1 << E_PSTA) | (1 << E_PRTA) | (1 << E_PRMA)));
    rd_chk(PST, 16'h3A80, "R10 pri aborts");
    fire(12'((1 << E_SSTA) | (1 << E_SRTA)));
    rd_chk(SST, 16'h1A80, "R10 sec target aborts");
    clr_all();
    // R11 set wins over clear
    step(); reg_we = 1'b1; reg_addr = SST; reg_wdata = 16'hFFFF; ev = 12'(1 << E_SSERR);
    step(); reg_we = 1'b0; ev = '0;
    rd_chk(SST, 16'h4280, "R11 set wins over clear");
    wr(RSN, 16'h0000);
    rd_chk(RSN, 16'h0001, "R11 reason write zero keeps");
    wr(RSN, 16'h0001);
    rd_chk(RSN, 16'h0000, "R11 reason cleared");
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule